// File: doc/BRIEF.md
# Axis Event Flag and Interrupt Unit

This block turns the event pulses of several counter axes into per-axis status pins and one shared interrupt line. Each axis receives single-cycle pulses for carry (overflow), borrow (underflow), compare match and index. It also receives two levels from its counter: a negative-sign level and a count-direction level. From these it drives two outputs per axis.

The primary flag is active low. It follows one chosen event and can work in either of two modes. In the held mode it stays low until the host releases it with a per-axis status clear. In the pulse mode it drops for exactly one clock. The secondary flag shows one of three things: the index event as a one-clock low pulse, the counter sign (high while negative), or the count direction (high while counting up). Either flag can be switched off, and it then rests high.

Every selected primary event also sets that axis's bit in an interrupt status vector. Each status bit is released by a write-one-to-clear strobe. A single active-low interrupt line is low while any status bit is set, and the status vector tells the host which axis raised it. All outputs are registered. The asynchronous reset is released through a two-stage synchronizer inside the block.

Top module: `cnt_flag_irq`

## Requirements
- R1: During and after reset, with all inputs idle, every primary flag and every secondary flag is high, the status vector is zero and irq_n is high.
- R2: The primary source field of an axis (2 bits at pa_src[2i+1:2i]) selects the event: 2'b01 carry, 2'b10 borrow, 2'b11 compare match. Pulses of the events that are not selected leave the primary flag and the status bit unchanged.
- R3: With pa_hold[i]=1, a selected event drives pa_flag_n[i] low from the clock edge that samples it. The flag stays low until an edge samples st_clr[i]=1 with no selected event. An event in the same cycle as st_clr keeps the flag low.
- R4: With pa_hold[i]=0, each sampled selected event makes pa_flag_n[i] low for exactly the one following clock cycle.
- R5: A source code of 2'b00 disables a flag. A disabled primary flag or secondary flag stays high whatever the events and levels do, and a disabled primary flag sets no status bit.
- R6: Secondary source 2'b01 (index): a sampled index pulse makes sb_flag[i] low for the one following cycle, and it is high otherwise.
- R7: Secondary source 2'b10 (sign): sb_flag[i] equals the cnt_neg[i] value sampled at the previous edge, so it is high while the counter is negative.
- R8: Secondary source 2'b11 (direction): sb_flag[i] equals the cnt_up[i] value sampled at the previous edge, so it is high for up counting and low for down counting.
- R9: A selected primary event sets irq_stat[i] in either mode, and the bit stays set until irq_ack[i] is sampled high. If an event and irq_ack[i] fall in the same cycle, the bit stays set.
- R10: irq_n is low in exactly the cycles in which irq_stat is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_carry | input | N_AXES | Carry pulse per axis |
| ev_borrow | input | N_AXES | Borrow pulse per axis |
| ev_match | input | N_AXES | Compare-match pulse per axis |
| ev_index | input | N_AXES | Index pulse per axis |
| cnt_neg | input | N_AXES | Counter negative level per axis |
| cnt_up | input | N_AXES | Count direction level per axis (1 = up) |
| pa_src | input | 2*N_AXES | Primary flag source per axis |
| pa_hold | input | N_AXES | Primary flag mode per axis (1 = held, 0 = pulse) |
| sb_src | input | 2*N_AXES | Secondary flag source per axis |
| st_clr | input | N_AXES | Release of a held primary flag per axis |
| irq_ack | input | N_AXES | Write-one-to-clear strobe per status bit |
| pa_flag_n | output | N_AXES | Primary flag per axis, active low |
| sb_flag | output | N_AXES | Secondary flag per axis |
| irq_stat | output | N_AXES | Interrupt status vector |
| irq_n | output | 1 | Shared interrupt, active low |

## Verification
Two functions can fall in the same cycle here. One is a selected event together with the status clear of a held primary flag. The other is a selected event together with the acknowledge strobe of the matching status bit. In both cases the event must win. The bench provokes each collision by raising the event pulse and the clear or acknowledge in the same driven cycle on one axis. It then judges the result on the following cycle, where the flag must still be low and the status bit still set. A lone clear or acknowledge on the next cycle must then release them.

// File: rtl/cnt_flag_irq_pkg.sv
`timescale 1ns/1ps
package cnt_flag_irq_pkg;

  typedef enum logic [1:0] {
    PA_OFF    = 2'b00,
    PA_CARRY  = 2'b01,
    PA_BORROW = 2'b10,
    PA_MATCH  = 2'b11
  } pa_src_e;

  typedef enum logic [1:0] {
    SB_OFF   = 2'b00,
    SB_INDEX = 2'b01,
    SB_SIGN  = 2'b10,
    SB_DIR   = 2'b11
  } sb_src_e;

  typedef struct packed {
    logic carry;
    logic borrow;
    logic match;
  } axis_ev_t;

endpackage

// File: rtl/cfi_rst_sync.sv
`timescale 1ns/1ps
module cfi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cfi_flag_a.sv
`timescale 1ns/1ps
module cfi_flag_a
  import cnt_flag_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pa_src_e  src,
  input  logic     hold,
  input  axis_ev_t ev,
  input  logic     clr,
  output logic     hit,
  output logic     flag_n
);
  logic latch_q, latch_d, latch_en;
  logic pulse_q, pulse_d;

  // event selection
  always_comb begin
    unique case (src)
      PA_CARRY:  hit = ev.carry;
      PA_BORROW: hit = ev.borrow;
      PA_MATCH:  hit = ev.match;
      default:   hit = 1'b0;
    endcase
  end

  // next state: a new event outranks the release
  always_comb begin
    latch_d  = latch_q;
    latch_en = 1'b0;
    if (src == PA_OFF || !hold) begin
      latch_d  = 1'b0;
      latch_en = latch_q;
    end else if (hit) begin
      latch_d  = 1'b1;
      latch_en = !latch_q;
    end else if (clr) begin
      latch_d  = 1'b0;
      latch_en = latch_q;
    end
    pulse_d = hit && !hold;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
    end else if (latch_en) begin
      latch_q <= latch_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
    end
  end

  assign flag_n = !(latch_q || pulse_q);
endmodule

// File: rtl/cfi_flag_b.sv
`timescale 1ns/1ps
module cfi_flag_b
  import cnt_flag_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  sb_src_e src,
  input  logic    index,
  input  logic    neg,
  input  logic    up,
  output logic    flag
);
  logic flag_q, flag_d;

  always_comb begin
    unique case (src)
      SB_INDEX: flag_d = !index;
      SB_SIGN:  flag_d = neg;
      SB_DIR:   flag_d = up;
      default:  flag_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b1;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/cfi_isr.sv
`timescale 1ns/1ps
module cfi_isr #(
  parameter int N_AXES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_AXES-1:0] set,
  input  logic [N_AXES-1:0] ack,
  output logic [N_AXES-1:0] stat,
  output logic              irq_n
);
  logic [N_AXES-1:0] stat_q, stat_d;
  logic              stat_en;
  logic              irq_n_q, irq_n_d;

  // set outranks acknowledge on the same bit
  always_comb begin
    stat_d  = (stat_q & ~ack) | set;
    stat_en = |(set | ack);
    irq_n_d = (stat_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_n_q <= 1'b1;
    end else if (stat_en) begin
      irq_n_q <= irq_n_d;
    end
  end

  assign stat  = stat_q;
  assign irq_n = irq_n_q;
endmodule

// File: rtl/cnt_flag_irq.sv
`timescale 1ns/1ps
module cnt_flag_irq
  import cnt_flag_irq_pkg::*;
#(
  parameter int N_AXES     = 4,
  parameter int RST_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_AXES-1:0]     ev_carry,
  input  logic [N_AXES-1:0]     ev_borrow,
  input  logic [N_AXES-1:0]     ev_match,
  input  logic [N_AXES-1:0]     ev_index,
  input  logic [N_AXES-1:0]     cnt_neg,
  input  logic [N_AXES-1:0]     cnt_up,
  input  logic [2*N_AXES-1:0]   pa_src,
  input  logic [N_AXES-1:0]     pa_hold,
  input  logic [2*N_AXES-1:0]   sb_src,
  input  logic [N_AXES-1:0]     st_clr,
  input  logic [N_AXES-1:0]     irq_ack,
  output logic [N_AXES-1:0]     pa_flag_n,
  output logic [N_AXES-1:0]     sb_flag,
  output logic [N_AXES-1:0]     irq_stat,
  output logic                  irq_n
);
  localparam int SRC_W = 2;

  logic              rst_n_sync;
  logic [N_AXES-1:0] ev_hit;

  cfi_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    axis_ev_t ev_bundle;
    assign ev_bundle = '{carry: ev_carry[a], borrow: ev_borrow[a], match: ev_match[a]};

    cfi_flag_a u_fa (
      .clk    (clk),
      .rst_n  (rst_n_sync),
      .src    (pa_src_e'(pa_src[SRC_W*a +: SRC_W])),
      .hold   (pa_hold[a]),
      .ev     (ev_bundle),
      .clr    (st_clr[a]),
      .hit    (ev_hit[a]),
      .flag_n (pa_flag_n[a])
    );

    cfi_flag_b u_fb (
      .clk   (clk),
      .rst_n (rst_n_sync),
      .src   (sb_src_e'(sb_src[SRC_W*a +: SRC_W])),
      .index (ev_index[a]),
      .neg   (cnt_neg[a]),
      .up    (cnt_up[a]),
      .flag  (sb_flag[a])
    );
  end

  cfi_isr #(.N_AXES(N_AXES)) u_isr (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .set   (ev_hit),
    .ack   (irq_ack),
    .stat  (irq_stat),
    .irq_n (irq_n)
  );
endmodule

// File: rtl/cnt_flag_irq_chk.sv
`timescale 1ns/1ps
module cnt_flag_irq_chk #(
  parameter int N_AXES = 4
) (
  input logic                clk,
  input logic                rst_q,
  input logic [N_AXES-1:0]   hit,
  input logic [N_AXES-1:0]   cnt_neg,
  input logic [N_AXES-1:0]   cnt_up,
  input logic [2*N_AXES-1:0] pa_src,
  input logic [N_AXES-1:0]   pa_hold,
  input logic [2*N_AXES-1:0] sb_src,
  input logic [N_AXES-1:0]   st_clr,
  input logic [N_AXES-1:0]   irq_ack,
  input logic [N_AXES-1:0]   pa_flag_n,
  input logic [N_AXES-1:0]   sb_flag,
  input logic [N_AXES-1:0]   irq_stat,
  input logic                irq_n
);
  for (genvar i = 0; i < N_AXES; i++) begin : g_chk
    AST_PA_OFF_HIGH: assert property (@(posedge clk) disable iff (!rst_q)
      (pa_src[2*i +: 2] == 2'b00) |=> pa_flag_n[i]); // R5
    AST_SB_OFF_HIGH: assert property (@(posedge clk) disable iff (!rst_q)
      (sb_src[2*i +: 2] == 2'b00) |=> sb_flag[i]); // R5
    AST_HELD_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_q)
      (pa_hold[i] && $past(pa_hold[i]) && pa_src[2*i +: 2] != 2'b00 && !st_clr[i] && !pa_flag_n[i])
      |=> !pa_flag_n[i]); // R3
    AST_PULSE_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_q)
      (!$past(pa_hold[i]) && !pa_flag_n[i]) |-> $past(hit[i])); // R4
    AST_SIGN_TRACKS: assert property (@(posedge clk) disable iff (!rst_q)
      (sb_src[2*i +: 2] == 2'b10) |=> (sb_flag[i] == $past(cnt_neg[i]))); // R7
    AST_DIR_TRACKS: assert property (@(posedge clk) disable iff (!rst_q)
      (sb_src[2*i +: 2] == 2'b11) |=> (sb_flag[i] == $past(cnt_up[i]))); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_q)
      (hit[i] && irq_ack[i]) |=> irq_stat[i]); // R9
  end

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_q)
    irq_n == (irq_stat == '0)); // R10
endmodule

bind cnt_flag_irq cnt_flag_irq_chk #(.N_AXES(N_AXES)) u_chk (
  .clk       (clk),
  .rst_q     (rst_n_sync),
  .hit       (ev_hit),
  .cnt_neg   (cnt_neg),
  .cnt_up    (cnt_up),
  .pa_src    (pa_src),
  .pa_hold   (pa_hold),
  .sb_src    (sb_src),
  .st_clr    (st_clr),
  .irq_ack   (irq_ack),
  .pa_flag_n (pa_flag_n),
  .sb_flag   (sb_flag),
  .irq_stat  (irq_stat),
  .irq_n     (irq_n)
);

// File: tb/cnt_flag_irq_test.sv
`timescale 1ns/1ps
module cnt_flag_irq_test;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] ev_carry = '0, ev_borrow = '0, ev_match = '0, ev_index = '0;
  logic [N-1:0] cnt_neg = '0, cnt_up = '0, pa_hold = '0, st_clr = '0, irq_ack = '0;
  logic [2*N-1:0] pa_src = '0, sb_src = '0;
  logic [N-1:0] pa_flag_n, sb_flag, irq_stat;
  logic irq_n;

  always #10 clk = ~clk;  // 50 MHz

  cnt_flag_irq #(.N_AXES(N)) uut (
    .clk(clk), .rst_n(rst_n), .ev_carry(ev_carry), .ev_borrow(ev_borrow),
    .ev_match(ev_match), .ev_index(ev_index), .cnt_neg(cnt_neg), .cnt_up(cnt_up),
    .pa_src(pa_src), .pa_hold(pa_hold), .sb_src(sb_src), .st_clr(st_clr),
    .irq_ack(irq_ack), .pa_flag_n(pa_flag_n), .sb_flag(sb_flag),
    .irq_stat(irq_stat), .irq_n(irq_n)
  );

  typedef struct {
    string      req;
    logic [N-1:0] fa;
    logic [N-1:0] fb;
    logic [N-1:0] st;
    logic         irq;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference state, built from the requirements
  logic [N-1:0] m_latch = '0, m_pulse = '0, m_fb = '1, m_st = '0;

  function automatic logic sel_hit(int a);
    case (pa_src[2*a +: 2])
      2'b01:   return ev_carry[a];
      2'b10:   return ev_borrow[a];
      2'b11:   return ev_match[a];
      default: return 1'b0;
    endcase
  endfunction

  task automatic tick();
    exp_t e;
    for (int a = 0; a < N; a++) begin
      logic h;
      h = sel_hit(a);
      if (pa_src[2*a +: 2] == 2'b00 || !pa_hold[a]) m_latch[a] = 1'b0;
      else if (h) m_latch[a] = 1'b1;
      else if (st_clr[a]) m_latch[a] = 1'b0;
      m_pulse[a] = h && !pa_hold[a];
      case (sb_src[2*a +: 2])
        2'b01:   m_fb[a] = !ev_index[a];
        2'b10:   m_fb[a] = cnt_neg[a];
        2'b11:   m_fb[a] = cnt_up[a];
        default: m_fb[a] = 1'b1;
      endcase
      m_st[a] = (m_st[a] && !irq_ack[a]) || h;
    end
    e.req = cur_req;
    e.fa  = ~(m_latch | m_pulse);
    e.fb  = m_fb;
    e.st  = m_st;
    e.irq = (m_st == '0);
    sb.push_back(e);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  // one-cycle pulse on one event vector bit
  task automatic pulse_carry(int a);  ev_carry[a] = 1;  tick(); ev_carry[a] = 0;  endtask
  task automatic pulse_borrow(int a); ev_borrow[a] = 1; tick(); ev_borrow[a] = 0; endtask
  task automatic pulse_match(int a);  ev_match[a] = 1;  tick(); ev_match[a] = 0;  endtask

  // monitor
  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checks += 4;
        if (pa_flag_n !== e.fa) begin
          failures++;
          $display("FAIL %s pa_flag_n act=%b exp=%b", e.req, pa_flag_n, e.fa);
        end
        if (sb_flag !== e.fb) begin
          failures++;
          $display("FAIL %s sb_flag act=%b exp=%b", e.req, sb_flag, e.fb);
        end
        if (irq_stat !== e.st) begin
          failures++;
          $display("FAIL %s irq_stat act=%b exp=%b", e.req, irq_stat, e.st);
        end
        if (irq_n !== e.irq) begin
          failures++;
          $display("FAIL %s irq_n act=%b exp=%b", e.req, irq_n, e.irq);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(20 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cur_req = "R1";
    idle(3);
    rst_n = 1'b1;
    idle(3);

    // R2 / R3: axis 0, carry source, held mode
    cur_req = "R2";
    pa_src[1:0] = 2'b01; pa_hold[0] = 1;
    pulse_borrow(0); pulse_match(0); idle(1);
    cur_req = "R3";
    pulse_carry(0); idle(3);
    st_clr[0] = 1; tick(); st_clr[0] = 0; idle(1);
    pulse_carry(0);
    ev_carry[0] = 1; st_clr[0] = 1; tick(); ev_carry[0] = 0; st_clr[0] = 0;
    idle(1);
    st_clr[0] = 1; tick(); st_clr[0] = 0;

    // R9: acknowledge, then collision of event with acknowledge
    cur_req = "R9";
    irq_ack[0] = 1; tick(); irq_ack[0] = 0; idle(1);
    pulse_carry(0);
    ev_carry[0] = 1; irq_ack[0] = 1; tick(); ev_carry[0] = 0; irq_ack[0] = 0;
    idle(1);
    irq_ack[0] = 1; st_clr[0] = 1; tick(); irq_ack[0] = 0; st_clr[0] = 0;

    // R4: axis 1, compare source, pulse mode
    cur_req = "R4";
    pa_src[3:2] = 2'b11; pa_hold[1] = 0;
    pulse_match(1); idle(2);
    ev_match[1] = 1; tick(); tick(); ev_match[1] = 0; idle(2);
    cur_req = "R2";
    pulse_carry(1); pulse_borrow(1); idle(1);
    cur_req = "R4";
    irq_ack[1] = 1; tick(); irq_ack[1] = 0;

    // R2: axis 2, borrow source, held mode
    cur_req = "R2";
    pa_src[5:4] = 2'b10; pa_hold[2] = 1;
    pulse_carry(2); pulse_match(2); pulse_borrow(2); idle(1);
    st_clr[2] = 1; irq_ack[2] = 1; tick(); st_clr[2] = 0; irq_ack[2] = 0;

    // R5: axis 3 primary disabled in both modes
    cur_req = "R5";
    pa_src[7:6] = 2'b00;
    for (int m = 0; m < 2; m++) begin
      pa_hold[3] = m[0];
      ev_carry[3] = 1; ev_borrow[3] = 1; ev_match[3] = 1; tick();
      ev_carry[3] = 0; ev_borrow[3] = 0; ev_match[3] = 0; idle(1);
    end
    ev_index[3] = 1; cnt_neg[3] = 1; cnt_up[3] = 0; tick();
    ev_index[3] = 0; cnt_neg[3] = 0; cnt_up[3] = 1; tick();

    // R6: axis 0 index
    cur_req = "R6";
    sb_src[1:0] = 2'b01;
    ev_index[0] = 1; tick(); ev_index[0] = 0; idle(2);

    // R7: axis 1 sign
    cur_req = "R7";
    sb_src[3:2] = 2'b10;
    cnt_neg[1] = 1; idle(2); cnt_neg[1] = 0; idle(2); cnt_neg[1] = 1; tick(); cnt_neg[1] = 0; tick();

    // R8: axis 2 direction
    cur_req = "R8";
    sb_src[5:4] = 2'b11;
    cnt_up[2] = 1; idle(2); cnt_up[2] = 0; idle(2); cnt_up[2] = 1; tick();

    // R10: several axes pending, released one at a time
    cur_req = "R10";
    ev_carry[0] = 1; ev_match[1] = 1; ev_borrow[2] = 1; tick();
    ev_carry[0] = 0; ev_match[1] = 0; ev_borrow[2] = 0;
    for (int a = 0; a < 3; a++) begin
      irq_ack[a] = 1; tick(); irq_ack[a] = 0; tick();
    end
    st_clr = '1; tick(); st_clr = '0; idle(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule